// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides whether an incoming Ethernet frame should be kept. It looks only at the six destination address octets. The receive path streams them in wire order: the first octet arrives with a start strobe and the remaining five follow. Idle cycles between octets are allowed. One cycle after the sixth octet, the block raises a one-cycle verdict strobe together with an accept/reject flag.

The filter uses four inputs to reach its verdict:
- a programmed station address;
- a 64-entry multicast hash table held in two 32-bit words;
- a mode word with flags for promiscuous acceptance, broadcast rejection and hashed unicast matching;
- a CRC-32 over the six destination octets. The top six bits of this CRC select one hash entry.

A simple write/read configuration port reaches all registers.

Top module: `rxf_addr_filter`

## Requirements
- R1: After reset the verdict strobe is low and every configuration register (selects 0 to 4) reads back as zero.
- R2: Select codes are 0 = mode, 1 = station low word, 2 = station high word, 3 = hash word 0, 4 = hash word 1. A mode write keeps only bits 3 (broadcast reject), 4 (hashed unicast), 5 (promiscuous) and 7 (loopback, stored and read back only), and the other mode bits read 0. The station high word keeps bits 15:0, and the hash words keep all 32 bits.
- R3: A frame starts when `rx_sof` and `rx_vld` are high together. Valid cycles carry octets in order, and idle cycles may fall between them. Exactly one verdict strobe appears in the cycle after the sixth octet is taken. Valid octets outside a started frame, including those after the sixth, produce no verdict.
- R4: The station address is octet 0 in high-word bits 15:8 and octet 1 in high-word bits 7:0. Octets 2, 3, 4 and 5 sit in low-word bits 31:24, 23:16, 15:8 and 7:0. A unicast destination equal to it is accepted.
- R5: With hashed unicast off, a unicast destination that differs from the station address is rejected, whatever the hash table holds.
- R6: The CRC uses polynomial 0x04C11DB7, seeded with all ones. It shifts in each octet LSB first, feeding back register bit 31 XOR the data bit, with no final inversion. Its bits 31:26 form an index, where index bit 5 picks hash word 1 over word 0 and bits 4:0 pick the bit. A destination with octet 0 bit 0 set, other than all ones, is accepted exactly when that bit is 1.
- R7: With both hash words all ones, every multicast destination is accepted.
- R8: The all-ones destination is accepted when mode bit 3 is 0 and rejected when it is 1, regardless of the hash table.
- R9: With mode bit 5 set, every destination is accepted.
- R10: With mode bit 4 set, a unicast destination that is not the station address is accepted exactly when its hash bit is 1.
- R11: A new start strobe in the middle of a frame discards the partial frame. Only the restarted frame produces a verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Register select for write and read |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| rx_sof | input | 1 | Marks the first destination octet |
| rx_vld | input | 1 | Octet valid |
| rx_byte | input | 8 | Destination octet |
| verdict_vld | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | Accept flag, valid with the strobe |

## Verification
A corrupt octet counter would show as a missing verdict, a doubled verdict or a verdict after stray octets. The bench counts strobes, so each of these is caught on the frame where it happens. A wrong CRC seed, bit order or hash word split moves the index, so a multicast whose single hash bit is set is rejected on its first verdict. Misplaced station octets make an exact-match unicast reject in the cycle after its sixth octet.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int WORD_W  = 32;
  localparam int OCTET_W = 8;

  typedef enum logic [2:0] {
    SEL_MODE   = 3'd0,
    SEL_STA_LO = 3'd1,
    SEL_STA_HI = 3'd2,
    SEL_HASH0  = 3'd3,
    SEL_HASH1  = 3'd4
  } cfg_sel_e;

  localparam int MODE_BCAST_OFF = 3;
  localparam int MODE_IHASH     = 4;
  localparam int MODE_PROMISC   = 5;
  localparam int MODE_LOOP      = 7;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  // one octet through the CRC register, least significant bit first
  function automatic logic [31:0] crc_octet(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[31] ^ d[i]) r = (r << 1) ^ CRC_POLY;
      else              r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int HI_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    sel,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          promisc,
  output logic          ihash,
  output logic          bcast_off,
  output logic [W-1:0]  sta_lo,
  output logic [HI_W-1:0] sta_hi,
  output logic [2*W-1:0] hash_tbl
);
  localparam int HPAD = W - HI_W;

  logic          promisc_q, ihash_q, bcast_off_q, loop_q;
  logic          promisc_d, ihash_d, bcast_off_d, loop_d;
  logic [W-1:0]  lo_q, lo_d, h0_q, h0_d, h1_q, h1_d;
  logic [HI_W-1:0] hi_q, hi_d;

  always_comb begin
    promisc_d   = promisc_q;
    ihash_d     = ihash_q;
    bcast_off_d = bcast_off_q;
    loop_d      = loop_q;
    lo_d        = lo_q;
    hi_d        = hi_q;
    h0_d        = h0_q;
    h1_d        = h1_q;
    if (we) begin
      case (cfg_sel_e'(sel))
        SEL_MODE: begin
          promisc_d   = wdata[MODE_PROMISC];
          ihash_d     = wdata[MODE_IHASH];
          bcast_off_d = wdata[MODE_BCAST_OFF];
          loop_d      = wdata[MODE_LOOP];
        end
        SEL_STA_LO: lo_d = wdata;
        SEL_STA_HI: hi_d = wdata[HI_W-1:0];
        SEL_HASH0:  h0_d = wdata;
        SEL_HASH1:  h1_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      promisc_q   <= 1'b0;
      ihash_q     <= 1'b0;
      bcast_off_q <= 1'b0;
      loop_q      <= 1'b0;
      lo_q        <= '0;
      hi_q        <= '0;
      h0_q        <= '0;
      h1_q        <= '0;
    end else if (we) begin
      promisc_q   <= promisc_d;
      ihash_q     <= ihash_d;
      bcast_off_q <= bcast_off_d;
      loop_q      <= loop_d;
      lo_q        <= lo_d;
      hi_q        <= hi_d;
      h0_q        <= h0_d;
      h1_q        <= h1_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (cfg_sel_e'(sel))
      SEL_MODE: begin
        rdata[MODE_PROMISC]   = promisc_q;
        rdata[MODE_IHASH]     = ihash_q;
        rdata[MODE_BCAST_OFF] = bcast_off_q;
        rdata[MODE_LOOP]      = loop_q;
      end
      SEL_STA_LO: rdata = lo_q;
      SEL_STA_HI: rdata = {{HPAD{1'b0}}, hi_q};
      SEL_HASH0:  rdata = h0_q;
      SEL_HASH1:  rdata = h1_q;
      default:    rdata = '0;
    endcase
  end

  assign promisc   = promisc_q;
  assign ihash     = ihash_q;
  assign bcast_off = bcast_off_q;
  assign sta_lo    = lo_q;
  assign sta_hi    = hi_q;
  assign hash_tbl  = {h1_q, h0_q};

  // R2: mode flags change only through a mode write
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && sel == SEL_MODE) |=> $stable({promisc_q, ihash_q, bcast_off_q, loop_q}));
  // R2: hash table changes only through a hash write
  a_r2_hash_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && (sel == SEL_HASH0 || sel == SEL_HASH1)) |=> $stable({h1_q, h0_q}));
endmodule

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture
  import rxf_pkg::*;
#(
  parameter int NOCT = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sof,
  input  logic                 vld,
  input  logic [OCTET_W-1:0]   octet,
  output logic                 take,
  output logic                 first,
  output logic                 last,
  output logic [NOCT*OCTET_W-1:0] dst
);
  localparam int CNT_W = $clog2(NOCT + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NOCT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NOCT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, idx;
  logic [NOCT-1:0][OCTET_W-1:0] oct_q, oct_d;

  always_comb begin
    first = vld && sof;
    idx   = sof ? '0 : cnt_q;
    take  = vld && (sof || (cnt_q != '0 && cnt_q < CNT_FULL));
    last  = take && (idx == CNT_LAST);
    cnt_d = take ? idx + 1'b1 : cnt_q;
    oct_d = oct_q;
    if (take) oct_d[idx] = octet;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      oct_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_d;
      oct_q <= oct_d;
    end
  end

  // octet 0 lands in the most significant byte of the flat view
  for (genvar g = 0; g < NOCT; g++) begin : g_flat
    assign dst[(NOCT-1-g)*OCTET_W +: OCTET_W] = oct_d[g];
  end

  // R3: position counter never runs past the address length
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  // R11: a start strobe always restarts at the second position
  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && sof) |=> cnt_q == CNT_W'(1));
endmodule

// File: rtl/rxf_crc_acc.sv
module rxf_crc_acc
  import rxf_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               first,
  input  logic [OCTET_W-1:0] octet,
  output logic [IDX_W-1:0]   idx
);
  logic [31:0] crc_q, crc_d, seed;

  always_comb begin
    seed  = first ? '1 : crc_q;
    crc_d = take ? crc_octet(seed, octet) : crc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= '1;
    else if (take) crc_q <= crc_d;
  end

  assign idx = crc_d[31 -: IDX_W];

  // R6: the accumulator moves only on accepted octets
  a_r6_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(crc_q));
endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
  import rxf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        rx_sof,
  input  logic        rx_vld,
  input  logic [7:0]  rx_byte,
  output logic        verdict_vld,
  output logic        verdict_accept
);
  localparam int NOCT  = 6;
  localparam int DST_W = NOCT * OCTET_W;
  localparam int HI_W  = DST_W - WORD_W;
  localparam int IDX_W = 6;
  localparam int GRP_BIT = DST_W - OCTET_W;

  logic promisc, ihash, bcast_off;
  logic [WORD_W-1:0] sta_lo;
  logic [HI_W-1:0]   sta_hi;
  logic [2*WORD_W-1:0] hash_tbl;
  logic take, first, last;
  logic [DST_W-1:0] dst;
  logic [IDX_W-1:0] hidx;
  logic is_bcast, is_group, sta_hit, hash_hit, accept_d;
  logic vld_q, acc_q;

  rxf_cfg_regs #(.W(WORD_W), .HI_W(HI_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .promisc(promisc), .ihash(ihash), .bcast_off(bcast_off),
    .sta_lo(sta_lo), .sta_hi(sta_hi), .hash_tbl(hash_tbl)
  );

  rxf_addr_capture #(.NOCT(NOCT)) u_cap (
    .clk(clk), .rst_n(rst_n), .sof(rx_sof), .vld(rx_vld), .octet(rx_byte),
    .take(take), .first(first), .last(last), .dst(dst)
  );

  rxf_crc_acc #(.IDX_W(IDX_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .take(take), .first(first), .octet(rx_byte),
    .idx(hidx)
  );

  always_comb begin
    is_bcast = &dst;
    is_group = dst[GRP_BIT];
    sta_hit  = (dst == {sta_hi, sta_lo});
    hash_hit = hash_tbl[hidx];
    if (promisc)       accept_d = 1'b1;
    else if (is_bcast) accept_d = !bcast_off;
    else if (is_group) accept_d = hash_hit;
    else               accept_d = sta_hit || (ihash && hash_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= 1'b0;
    else if (last) acc_q <= accept_d;
  end

  assign verdict_vld    = vld_q;
  assign verdict_accept = acc_q;

  // R3: a verdict strobe never lasts two cycles
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |=> !verdict_vld);
  // R9: promiscuous mode forces acceptance
  a_r9_promisc: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && $past(promisc)) |-> verdict_accept);
  // R8: broadcast reject wins when not promiscuous
  a_r8_bcast_off: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && $past(bcast_off && !promisc && (&dst))) |-> !verdict_accept);
endmodule

// File: tb/rxf_addr_filter_test.sv
module rxf_addr_filter_test;
  logic clk, rst_n, cfg_we, rx_sof, rx_vld;
  logic [2:0] cfg_sel;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [7:0] rx_byte;
  logic verdict_vld, verdict_accept;
  int n_chk, n_err, pulses;

  rxf_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_sof(rx_sof),
    .rx_vld(rx_vld), .rx_byte(rx_byte), .verdict_vld(verdict_vld),
    .verdict_accept(verdict_accept)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) if (rst_n && verdict_vld) pulses++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[31] ^ a[47 - 8*k - 7 + b];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    return c;
  endfunction

  function automatic int ref_idx(input logic [47:0] a);
    logic [31:0] c;
    c = ref_crc(a);
    return int'(c[31:26]);
  endfunction

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] s, input logic [31:0] exp, input string req);
    cfg_sel = s; #1;
    chk(cfg_rdata === exp, req, cfg_rdata, exp);
  endtask

  task automatic set_hash(input logic [63:0] h);
    wr(3'd3, h[31:0]);
    wr(3'd4, h[63:32]);
  endtask

  task automatic send(input logic [47:0] a, input bit gap, input bit exp, input string req);
    int p0;
    p0 = pulses;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      if (gap && i == 3) begin
        rx_vld = 1'b0; rx_sof = 1'b0;
        @(posedge clk); #1;
      end
      rx_vld = 1'b1; rx_sof = (i == 0); rx_byte = a[47 - 8*i -: 8];
    end
    @(posedge clk); #1;
    rx_vld = 1'b0; rx_sof = 1'b0;
    @(negedge clk);
    chk(verdict_vld === 1'b1, {req, " strobe"}, 32'(verdict_vld), 32'd1);
    chk(verdict_accept === exp, {req, " accept"}, 32'(verdict_accept), 32'(exp));
    @(negedge clk);
    chk(pulses == p0 + 1, {req, " one strobe"}, 32'(pulses - p0), 32'd1);
  endtask

  task automatic t_reset;
    chk(verdict_vld === 1'b0, "R1 verdict low", 32'(verdict_vld), 32'd0);
    for (int s = 0; s < 5; s++) rd_chk(3'(s), 32'd0, "R1 reg zero");
  endtask

  task automatic t_regs;
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk(3'd0, 32'h0000_00B8, "R2 mode mask");
    wr(3'd0, 32'h0000_0080);
    rd_chk(3'd0, 32'h0000_0080, "R2 loopback only");
    wr(3'd2, 32'hDEAD_1234);
    rd_chk(3'd2, 32'h0000_1234, "R2 station high");
    wr(3'd1, 32'hCAFE_F00D);
    rd_chk(3'd1, 32'hCAFE_F00D, "R2 station low");
    set_hash(64'h0123_4567_89AB_CDEF);
    rd_chk(3'd3, 32'h89AB_CDEF, "R2 hash0");
    rd_chk(3'd4, 32'h0123_4567, "R2 hash1");
    wr(3'd0, 32'h0);
  endtask

  task automatic t_station;
    wr(3'd2, 32'h0000_0211);
    wr(3'd1, 32'h2233_4455);
    set_hash(64'h0);
    send(48'h0211_2233_4455, 1'b0, 1'b1, "R4 exact match");
    send(48'h0211_2233_4455, 1'b1, 1'b1, "R3 gap R4 match");
    send(48'h0211_2233_4456, 1'b0, 1'b0, "R5 last octet differs");
    send(48'h1102_2233_4455, 1'b0, 1'b0, "R5 swapped high octets");
    set_hash(64'hFFFF_FFFF_FFFF_FFFF);
    send(48'h0299_8877_6655, 1'b0, 1'b0, "R5 hash full ihash off");
  endtask

  task automatic t_ihash;
    logic [47:0] a;
    logic [63:0] h;
    a = 48'h0299_8877_6655;
    wr(3'd0, 32'h10);
    set_hash(64'hFFFF_FFFF_FFFF_FFFF);
    send(a, 1'b0, 1'b1, "R10 hashed unicast hit");
    h = '1; h[ref_idx(a)] = 1'b0;
    set_hash(h);
    send(a, 1'b0, 1'b0, "R10 hashed unicast miss");
    send(48'h0211_2233_4455, 1'b0, 1'b1, "R10 station still matches");
    wr(3'd0, 32'h0);
  endtask

  task automatic t_mcast;
    logic [47:0] lo_a, hi_a, a;
    logic [63:0] h;
    bit got_lo, got_hi;
    got_lo = 0; got_hi = 0; lo_a = '0; hi_a = '0;
    for (int k = 0; k < 256; k++) begin
      a = {40'h01_00_5E_00_00, 8'(k)};
      if (ref_idx(a) >= 32 && !got_hi) begin hi_a = a; got_hi = 1; end
      if (ref_idx(a) <  32 && !got_lo) begin lo_a = a; got_lo = 1; end
    end
    h = '0; h[ref_idx(lo_a)] = 1'b1;
    set_hash(h);
    send(lo_a, 1'b0, 1'b1, "R6 hash word0 hit");
    send(hi_a, 1'b0, 1'b0, "R6 other word clear");
    h = '0; h[ref_idx(hi_a)] = 1'b1;
    set_hash(h);
    send(hi_a, 1'b0, 1'b1, "R6 hash word1 hit");
    h = '1; h[ref_idx(hi_a)] = 1'b0;
    set_hash(h);
    send(hi_a, 1'b0, 1'b0, "R6 only its bit clear");
    set_hash(64'hFFFF_FFFF_FFFF_FFFF);
    send(48'h3333_0000_0001, 1'b0, 1'b1, "R7 all ones multicast a");
    send(48'h0180_C200_0000, 1'b1, 1'b1, "R7 all ones multicast b");
    set_hash(64'h0);
    send(48'h3333_0000_0001, 1'b0, 1'b0, "R7 empty table rejects");
  endtask

  task automatic t_bcast;
    set_hash(64'h0);
    wr(3'd0, 32'h0);
    send(48'hFFFF_FFFF_FFFF, 1'b0, 1'b1, "R8 broadcast allowed");
    wr(3'd0, 32'h08);
    send(48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, "R8 broadcast rejected");
    set_hash(64'hFFFF_FFFF_FFFF_FFFF);
    send(48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, "R8 rejected with full hash");
  endtask

  task automatic t_promisc;
    set_hash(64'h0);
    wr(3'd0, 32'h28);
    send(48'h0A0B_0C0D_0E0F, 1'b0, 1'b1, "R9 foreign unicast");
    send(48'hFFFF_FFFF_FFFF, 1'b0, 1'b1, "R9 broadcast with reject");
    send(48'h0100_5E00_0007, 1'b0, 1'b1, "R9 multicast empty table");
    wr(3'd0, 32'h0);
  endtask

  task automatic t_stray;
    int p0;
    p0 = pulses;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      rx_vld = 1'b1; rx_sof = 1'b0; rx_byte = 8'(i);
    end
    @(posedge clk); #1; rx_vld = 1'b0;
    repeat (3) @(negedge clk);
    chk(pulses == p0, "R3 stray octets no verdict", 32'(pulses - p0), 32'd0);
  endtask

  task automatic t_restart;
    int p0;
    logic [47:0] a;
    a = 48'h0211_2233_4455;
    p0 = pulses;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      rx_vld = 1'b1; rx_sof = (i == 0); rx_byte = 8'hFF;
    end
    @(posedge clk); #1; rx_vld = 1'b0; rx_sof = 1'b0;
    send(a, 1'b0, 1'b1, "R11 restarted frame");
    chk(pulses == p0 + 1, "R11 partial frame dropped", 32'(pulses - p0), 32'd1);
  endtask

  initial begin
    #(8 * 100000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0; pulses = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    rx_sof = 1'b0; rx_vld = 1'b0; rx_byte = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_station();
    t_ihash();
    t_mcast();
    t_bcast();
    t_promisc();
    t_stray();
    t_restart();
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule